// File: doc/BRIEF.md
# Readout Cell Formatter with Periodic Spacer Cells

This block packs detector readout data into fixed cells of three 16-bit words and streams the words to a downstream readout FIFO. It has four sources, each with its own valid/ready handshake:

- hit records, each carrying a channel, a gate count, a range code, a trigger ID, a local event number and a TDC count;
- 32-bit raw TDC words tagged with a TDC ID;
- status messages;
- global event ticks, each carrying a 32-bit event number.

The top four bits of the first word of a cell identify its type. Hit cells put the channel number there, so channels 0 to 23 always give a top nibble between 0000 and 1011.

Every `SPACER_PERIOD` accepted ticks (64 by default), the block queues a spacer cell. The spacer holds bits 31:4 of the event number of the tick that closed the period. It also holds a 16-bit running sum of every hit-cell word accepted since the previous spacer.

Sources are served one whole cell at a time, in fixed priority. A single controller walks the cell out word by word and stalls whenever the FIFO is not ready. The controller has four states:

- `ST_IDLE`: picks a source.
- `ST_WORD1`, `ST_WORD2`, `ST_WORD3`: present the three words in turn.

Its transitions are:

- emit (`ST_IDLE` to `ST_WORD1`): a source is granted and yields a cell.
- advance (`ST_WORD1` to `ST_WORD2`, and `ST_WORD2` to `ST_WORD3`): taken on a handshake on the output.
- finish (`ST_WORD3` to `ST_IDLE`): taken on the last handshake.
- hold: every state stays put otherwise. This includes a dropped hit, which is accepted in `ST_IDLE` without leaving it.

Top module: `cell_packer`

## Requirements
- R1: Every cell leaves as three words on `out_word`, in the order word 1, word 2, word 3. One word is transferred per cycle in which `out_valid` and `out_ready` are both high. The words of one cell are never interleaved with words of another cell.
- R2: A hit cell is laid out as follows.
  - Word 1 is {channel[4:0], gate[10:0]}.
  - Word 2 is {range[1:0], trigger[1:0], event[11:0]}. Range codes are 00 small, 01 medium and 10 large. Trigger codes are 00 narrow, 01 wide, 10 pedestal and 11 calibration.
  - Word 3 is the 16-bit TDC count.
- R3: A raw cell is laid out as follows.
  - Word 1 is {1101, TDC ID[3:0], 8'h00}.
  - Word 2 is raw[31:16].
  - Word 3 is raw[15:0].
- R4: A status cell is laid out as follows.
  - Word 1 is {1110, class[1:0], device[3:0], address[5:0]}.
  - Word 2 is value[31:16].
  - Word 3 is value[15:0].
- R5: After every 64th accepted tick, a spacer cell is emitted. Its word 1 is {1100, N[31:20]} and its word 2 is N[19:4], where N is the event number of that 64th tick. No spacer is emitted before the 64th tick.
- R6: Word 3 of a spacer is the sum, modulo 2^16, of all words of the hit cells accepted since the previous spacer. The sum restarts from zero once the spacer has been taken.
- R7: When several sources are pending in `ST_IDLE`, they are served in this order: pending spacer, status, hit, raw. A cell that is already in progress always completes first.
- R8: A hit record with a channel above 23 is accepted but produces no cell. It increments `drop_count`, which saturates at its maximum and never decreases.
- R9: While a cell is in progress, no source ready is high. At most one source ready is high in any cycle. While `out_valid` is high and `out_ready` is low, `out_word` holds its value.
- R10: While a spacer is pending, `tick_ready` is low.
- R11: After reset:
  - `out_valid` is low;
  - `drop_count` is zero;
  - `tick_ready` is high;
  - the checksum and the tick count are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | Hit record offered |
| hit_ready | output | 1 | Hit record accepted this cycle |
| hit_chan | input | 5 | Channel number |
| hit_gate | input | 11 | Gate count |
| hit_range | input | 2 | Range code |
| hit_trig | input | 2 | Trigger ID |
| hit_evt | input | 12 | Local event number |
| hit_tdc | input | 16 | TDC count |
| raw_valid | input | 1 | Raw word offered |
| raw_ready | output | 1 | Raw word accepted this cycle |
| raw_src | input | 4 | TDC ID |
| raw_data | input | 32 | Raw TDC word |
| sts_valid | input | 1 | Status message offered |
| sts_ready | output | 1 | Status message accepted this cycle |
| sts_class | input | 2 | Status class |
| sts_dev | input | 4 | Device number |
| sts_addr | input | 6 | Status address |
| sts_value | input | 32 | Status value |
| tick_valid | input | 1 | Global event tick offered |
| tick_ready | output | 1 | Tick accepted when high |
| tick_num | input | 32 | Global event number |
| out_valid | output | 1 | Word available to the FIFO |
| out_ready | input | 1 | FIFO can take a word |
| out_word | output | 16 | Cell word |
| drop_count | output | DROP_W | Saturating count of dropped hit records |

## Verification
The hardest situation to reach is a spacer that becomes pending while another cell is stalled mid-flight. In that case `tick_ready` must stay low, the stalled word must hold, and the spacer must follow the stalled cell rather than cut into it. The stimulus gets there by holding `out_ready` low, starting a raw cell, and then completing a full period of 64 ticks underneath the stall. A second stress point is the checksum: the hit words are chosen so that their sum wraps past 2^16 before the first spacer.

// File: rtl/cell_fmt_pkg.sv
package cell_fmt_pkg;

    localparam int WORD_W  = 16;
    localparam int CH_W    = 5;
    localparam int GATE_W  = 11;
    localparam int LEVT_W  = 12;
    localparam int CODE_W  = 2;
    localparam int TDC_W   = 16;
    localparam int GEVT_W  = 32;
    localparam int GHI_W   = GEVT_W - 4;
    localparam int RAW_W   = 32;
    localparam int SRCID_W = 4;
    localparam int CLS_W   = 2;
    localparam int DEV_W   = 4;
    localparam int SADR_W  = 6;

    // source slots, lower index wins arbitration
    localparam int SRC_N      = 4;
    localparam int SRC_SPACER = 0;
    localparam int SRC_STATUS = 1;
    localparam int SRC_HIT    = 2;
    localparam int SRC_RAW    = 3;

    localparam logic [3:0] HDR_SPACER = 4'b1100;
    localparam logic [3:0] HDR_RAW    = 4'b1101;
    localparam logic [3:0] HDR_STATUS = 4'b1110;

    typedef struct packed {
        logic [WORD_W-1:0] w1;
        logic [WORD_W-1:0] w2;
        logic [WORD_W-1:0] w3;
    } cell_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WORD1,
        ST_WORD2,
        ST_WORD3
    } fmt_state_e;

    function automatic cell_t pack_hit(
        input logic [CH_W-1:0]   chan,
        input logic [GATE_W-1:0] gate,
        input logic [CODE_W-1:0] rng,
        input logic [CODE_W-1:0] trig,
        input logic [LEVT_W-1:0] evt,
        input logic [TDC_W-1:0]  tdc
    );
        cell_t c;
        c.w1 = {chan, gate};
        c.w2 = {rng, trig, evt};
        c.w3 = tdc;
        return c;
    endfunction

    function automatic cell_t pack_raw(
        input logic [SRCID_W-1:0] id,
        input logic [RAW_W-1:0]   data
    );
        cell_t c;
        c.w1 = {HDR_RAW, id, 8'h00};
        c.w2 = data[RAW_W-1:WORD_W];
        c.w3 = data[WORD_W-1:0];
        return c;
    endfunction

    function automatic cell_t pack_status(
        input logic [CLS_W-1:0]  cls,
        input logic [DEV_W-1:0]  dev,
        input logic [SADR_W-1:0] adr,
        input logic [RAW_W-1:0]  val
    );
        cell_t c;
        c.w1 = {HDR_STATUS, cls, dev, adr};
        c.w2 = val[RAW_W-1:WORD_W];
        c.w3 = val[WORD_W-1:0];
        return c;
    endfunction

    function automatic cell_t pack_spacer(
        input logic [GHI_W-1:0]  ghi,
        input logic [WORD_W-1:0] sum
    );
        cell_t c;
        c.w1 = {HDR_SPACER, ghi[GHI_W-1:WORD_W]};
        c.w2 = ghi[WORD_W-1:0];
        c.w3 = sum;
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] cell_word_sum(input cell_t c);
        return c.w1 + c.w2 + c.w3;
    endfunction

endpackage

// File: rtl/cell_prio_arb.sv
module cell_prio_arb #(
    parameter int N = 4
) (
    input  logic         en,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (en && req[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cell_event_tally.sv
module cell_event_tally import cell_fmt_pkg::*; #(
    parameter int PERIOD = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_valid,
    input  logic [GEVT_W-1:0] tick_num,
    output logic              tick_ready,
    input  logic              take,
    output logic              pend,
    output logic [GHI_W-1:0]  ghi
);
    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] count_q;
    logic             accept;

    assign tick_ready = !pend;
    assign accept     = tick_valid && tick_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            pend    <= 1'b0;
            ghi     <= '0;
        end else begin
            if (take) begin
                pend <= 1'b0;
            end
            if (accept) begin
                if (count_q == LAST) begin
                    count_q <= '0;
                    pend    <= 1'b1;
                    ghi     <= tick_num[GEVT_W-1:4];
                end else begin
                    count_q <= count_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cell_hit_sum.sv
module cell_hit_sum #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         add_en,
    input  logic [W-1:0] add_val,
    input  logic         clear,
    output logic [W-1:0] sum
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum <= '0;
        end else if (clear) begin
            sum <= '0;
        end else if (add_en) begin
            sum <= sum + add_val;
        end
    end
endmodule

// File: rtl/cell_packer.sv
module cell_packer import cell_fmt_pkg::*; #(
    parameter int SPACER_PERIOD = 64,
    parameter int NUM_CH        = 24,
    parameter int DROP_W        = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hit_valid,
    output logic               hit_ready,
    input  logic [4:0]         hit_chan,
    input  logic [10:0]        hit_gate,
    input  logic [1:0]         hit_range,
    input  logic [1:0]         hit_trig,
    input  logic [11:0]        hit_evt,
    input  logic [15:0]        hit_tdc,
    input  logic               raw_valid,
    output logic               raw_ready,
    input  logic [3:0]         raw_src,
    input  logic [31:0]        raw_data,
    input  logic               sts_valid,
    output logic               sts_ready,
    input  logic [1:0]         sts_class,
    input  logic [3:0]         sts_dev,
    input  logic [5:0]         sts_addr,
    input  logic [31:0]        sts_value,
    input  logic               tick_valid,
    output logic               tick_ready,
    input  logic [31:0]        tick_num,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [15:0]        out_word,
    output logic [DROP_W-1:0]  drop_count
);
    localparam logic [CH_W-1:0] CH_LIMIT = CH_W'(NUM_CH - 1);

    fmt_state_e        state_q, state_d;
    cell_t             cell_q, cell_d;
    logic [SRC_N-1:0]  req, grant;
    logic              spacer_pend;
    logic [GHI_W-1:0]  spacer_ghi;
    logic [WORD_W-1:0] hit_sum;
    logic              hit_bad, emit, hit_add, spacer_take;
    cell_t             hit_cell;

    assign req[SRC_SPACER] = spacer_pend;
    assign req[SRC_STATUS] = sts_valid;
    assign req[SRC_HIT]    = hit_valid;
    assign req[SRC_RAW]    = raw_valid;

    cell_prio_arb #(.N(SRC_N)) u_arb (
        .en    (state_q == ST_IDLE),
        .req   (req),
        .grant (grant)
    );

    cell_event_tally #(.PERIOD(SPACER_PERIOD)) u_tally (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_valid (tick_valid),
        .tick_num   (tick_num),
        .tick_ready (tick_ready),
        .take       (spacer_take),
        .pend       (spacer_pend),
        .ghi        (spacer_ghi)
    );

    assign hit_cell    = pack_hit(hit_chan, hit_gate, hit_range, hit_trig, hit_evt, hit_tdc);
    assign hit_bad     = hit_chan > CH_LIMIT;
    assign hit_add     = grant[SRC_HIT] && !hit_bad;
    assign spacer_take = grant[SRC_SPACER];
    assign emit        = (|grant) && !(grant[SRC_HIT] && hit_bad);

    cell_hit_sum #(.W(WORD_W)) u_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .add_en  (hit_add),
        .add_val (cell_word_sum(hit_cell)),
        .clear   (spacer_take),
        .sum     (hit_sum)
    );

    // cell selected in idle
    always_comb begin
        cell_d = cell_q;
        if (grant[SRC_SPACER]) begin
            cell_d = pack_spacer(spacer_ghi, hit_sum);
        end else if (grant[SRC_STATUS]) begin
            cell_d = pack_status(sts_class, sts_dev, sts_addr, sts_value);
        end else if (hit_add) begin
            cell_d = hit_cell;
        end else if (grant[SRC_RAW]) begin
            cell_d = pack_raw(raw_src, raw_data);
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (emit)      state_d = ST_WORD1;
            ST_WORD1: if (out_ready) state_d = ST_WORD2;
            ST_WORD2: if (out_ready) state_d = ST_WORD3;
            ST_WORD3: if (out_ready) state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cell_q <= '0;
        end else if (state_q == ST_IDLE && emit) begin
            cell_q <= cell_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_count <= '0;
        end else if (grant[SRC_HIT] && hit_bad && drop_count != '1) begin
            drop_count <= drop_count + 1'b1;
        end
    end

    // outputs
    always_comb begin
        hit_ready = grant[SRC_HIT];
        raw_ready = grant[SRC_RAW];
        sts_ready = grant[SRC_STATUS];
        out_valid = 1'b1;
        out_word  = '0;
        unique case (state_q)
            ST_IDLE:  out_valid = 1'b0;
            ST_WORD1: out_word  = cell_q.w1;
            ST_WORD2: out_word  = cell_q.w2;
            ST_WORD3: out_word  = cell_q.w3;
            default:  out_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/cell_packer_chk.sv
module cell_packer_chk #(
    parameter int NUM_CH = 24,
    parameter int DROP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic              out_ready,
    input logic [15:0]       out_word,
    input logic              hit_valid,
    input logic              hit_ready,
    input logic [4:0]        hit_chan,
    input logic              raw_ready,
    input logic              sts_ready,
    input logic              tick_ready,
    input logic              spacer_pend,
    input logic [DROP_W-1:0] drop_count
);
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_word));

    // R9
    one_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit_ready, raw_ready, sts_ready}));

    // R9
    busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(hit_ready || raw_ready || sts_ready));

    // R10
    tick_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spacer_pend |-> !tick_ready);

    // R7
    spacer_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spacer_pend && !out_valid |-> !(hit_ready || raw_ready || sts_ready));

    // R8
    drop_no_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid && hit_ready && hit_chan > 5'(NUM_CH - 1) |=> !out_valid);

    // R8
    drop_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> drop_count >= $past(drop_count));
endmodule

bind cell_packer cell_packer_chk #(.NUM_CH(NUM_CH), .DROP_W(DROP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_word    (out_word),
    .hit_valid   (hit_valid),
    .hit_ready   (hit_ready),
    .hit_chan    (hit_chan),
    .raw_ready   (raw_ready),
    .sts_ready   (sts_ready),
    .tick_ready  (tick_ready),
    .spacer_pend (spacer_pend),
    .drop_count  (drop_count)
);

// File: tb/cell_packer_tb_top.sv
module cell_packer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CAP_N = 256;

    typedef struct packed {
        logic [1:0]  kind;   // 0 hit, 1 raw, 2 status
        logic [31:0] p0;
        logic [15:0] p1;
        logic [15:0] e1;
        logic [15:0] e2;
        logic [15:0] e3;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{2'd0, {5'd5, 11'h123, 2'b01, 2'b10, 12'hABC}, 16'hBEEF, 16'h2923, 16'h6ABC, 16'hBEEF},
        '{2'd1, 32'h1234_5678, 16'h0003, 16'hD300, 16'h1234, 16'h5678},
        '{2'd2, 32'hDEAD_BEEF, {4'd0, 2'b10, 4'd9, 6'h2A}, 16'hEA6A, 16'hDEAD, 16'hBEEF},
        '{2'd0, {5'd23, 11'h7FF, 2'b10, 2'b11, 12'hFFF}, 16'h0001, 16'hBFFF, 16'hBFFF, 16'h0001},
        '{2'd2, 32'h0000_0000, 16'h0000, 16'hE000, 16'h0000, 16'h0000},
        '{2'd0, {5'd0, 11'd0, 2'b00, 2'b00, 12'h001}, 16'h0000, 16'h0000, 16'h0001, 16'h0000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hit_valid = 1'b0, raw_valid = 1'b0, sts_valid = 1'b0, tick_valid = 1'b0;
    logic hit_ready, raw_ready, sts_ready, tick_ready;
    logic [4:0]  hit_chan = '0;
    logic [10:0] hit_gate = '0;
    logic [1:0]  hit_range = '0, hit_trig = '0, sts_class = '0;
    logic [11:0] hit_evt = '0;
    logic [15:0] hit_tdc = '0;
    logic [3:0]  raw_src = '0, sts_dev = '0;
    logic [31:0] raw_data = '0, sts_value = '0, tick_num = '0;
    logic [5:0]  sts_addr = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_word;
    logic [7:0]  drop_count;

    int errors = 0;
    int checks = 0;
    int cap_n = 0;
    int ncell = 0;
    bit done = 1'b0;
    logic [15:0] cap [0:CAP_N-1];
    logic [15:0] sum16 = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cell_packer dut_i (
        .clk(clk), .rst_n(rst_n),
        .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_chan(hit_chan), .hit_gate(hit_gate),
        .hit_range(hit_range), .hit_trig(hit_trig), .hit_evt(hit_evt), .hit_tdc(hit_tdc),
        .raw_valid(raw_valid), .raw_ready(raw_ready), .raw_src(raw_src), .raw_data(raw_data),
        .sts_valid(sts_valid), .sts_ready(sts_ready), .sts_class(sts_class), .sts_dev(sts_dev),
        .sts_addr(sts_addr), .sts_value(sts_value),
        .tick_valid(tick_valid), .tick_ready(tick_ready), .tick_num(tick_num),
        .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
        .drop_count(drop_count)
    );

    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready && cap_n < CAP_N) begin
            cap[cap_n] = out_word;
            cap_n++;
        end
    end

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_cell(input string tag, input logic [15:0] e1, input logic [15:0] e2,
                              input logic [15:0] e3);
        logic [47:0] act;
        if (3 * ncell + 2 < CAP_N)
            act = {cap[3*ncell], cap[3*ncell+1], cap[3*ncell+2]};
        else
            act = 'x;
        check(tag, act, {e1, e2, e3});
        ncell++;
    endtask

    task automatic wait_cells(input int n);
        for (int k = 0; k < 400 && cap_n < 3 * n; k++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send_hit(input logic [31:0] p0, input logic [15:0] p1);
        @(negedge clk);
        {hit_chan, hit_gate, hit_range, hit_trig, hit_evt} = p0;
        hit_tdc = p1;
        hit_valid = 1'b1;
        #1;
        while (!hit_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1 hit_valid = 1'b0;
    endtask

    task automatic send_raw(input logic [31:0] p0, input logic [15:0] p1);
        @(negedge clk);
        raw_data = p0;
        raw_src = p1[3:0];
        raw_valid = 1'b1;
        #1;
        while (!raw_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1 raw_valid = 1'b0;
    endtask

    task automatic send_sts(input logic [31:0] p0, input logic [15:0] p1);
        @(negedge clk);
        sts_value = p0;
        {sts_class, sts_dev, sts_addr} = p1[11:0];
        sts_valid = 1'b1;
        #1;
        while (!sts_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1 sts_valid = 1'b0;
    endtask

    task automatic send_tick(input logic [31:0] num);
        @(negedge clk);
        tick_num = num;
        tick_valid = 1'b1;
        #1;
        while (!tick_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1 tick_valid = 1'b0;
    endtask

    function automatic string tag_of(input logic [1:0] kind);
        if (kind == 2'd0) return "R1 R2 hit cell";
        if (kind == 2'd1) return "R3 raw cell";
        return "R4 status cell";
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 out_valid after reset", {47'd0, out_valid}, 48'd0);
        check("R11 drop_count after reset", {40'd0, drop_count}, 48'd0);
        check("R11 tick_ready after reset", {47'd0, tick_ready}, 48'd1);

        // table walk: one cell per vector
        for (int v = 0; v < 6; v++) begin
            case (VECS[v].kind)
                2'd0: send_hit(VECS[v].p0, VECS[v].p1);
                2'd1: send_raw(VECS[v].p0, VECS[v].p1);
                default: send_sts(VECS[v].p0, VECS[v].p1);
            endcase
            wait_cells(ncell + 1);
            if (VECS[v].kind == 2'd0) sum16 = sum16 + VECS[v].e1 + VECS[v].e2 + VECS[v].e3;
            check_cell(tag_of(VECS[v].kind), VECS[v].e1, VECS[v].e2, VECS[v].e3);
        end

        // R8 out-of-range channels dropped
        send_hit({5'd24, 11'h001, 2'b00, 2'b00, 12'h002}, 16'h1111);
        repeat (5) @(negedge clk);
        check("R8 no cell for channel 24", 48'(cap_n), 48'(3 * ncell));
        check("R8 drop_count after first drop", {40'd0, drop_count}, 48'd1);
        send_hit({5'd31, 11'h7FF, 2'b11, 2'b11, 12'hFFF}, 16'hFFFF);
        repeat (5) @(negedge clk);
        check("R8 no cell for channel 31", 48'(cap_n), 48'(3 * ncell));
        check("R8 drop_count after second drop", {40'd0, drop_count}, 48'd2);

        // R5 first spacer, R6 checksum with wrap
        for (int i = 0; i < 63; i++) send_tick(32'h0000_0100 + i);
        repeat (5) @(negedge clk);
        check("R5 no spacer before 64th tick", 48'(cap_n), 48'(3 * ncell));
        send_tick(32'hFEDC_BA98);
        wait_cells(ncell + 1);
        check_cell("R5 R6 first spacer", 16'hCFED, 16'hCBA9, sum16);
        sum16 = '0;

        // R6 restart, R10 and R9 under a stall
        send_hit({5'd0, 11'd0, 2'b00, 2'b00, 12'h001}, 16'h0000);
        wait_cells(ncell + 1);
        check_cell("R2 hit before stall", 16'h0000, 16'h0001, 16'h0000);
        sum16 = 16'h0001;
        @(posedge clk); #1 out_ready = 1'b0;
        send_raw(32'hA5A5_0F0F, 16'h0001);
        for (int i = 0; i < 63; i++) send_tick(32'h0000_0200 + i);
        send_tick(32'h0000_0010);
        @(negedge clk);
        check("R10 tick_ready while spacer pending", {47'd0, tick_ready}, 48'd0);
        check("R9 stalled word held", {31'd0, out_valid, out_word}, {31'd0, 1'b1, 16'hD100});
        check("R9 no cell leaves while stalled", 48'(cap_n), 48'(3 * ncell));
        @(posedge clk); #1 out_ready = 1'b1;
        wait_cells(ncell + 2);
        check_cell("R7 R3 stalled raw cell completes first", 16'hD100, 16'hA5A5, 16'h0F0F);
        check_cell("R6 spacer sum restarted", 16'hC000, 16'h0001, sum16);

        // R7 priority among simultaneous sources
        fork
            send_hit(VECS[3].p0, VECS[3].p1);
            send_raw(VECS[1].p0, VECS[1].p1);
            send_sts(VECS[4].p0, VECS[4].p1);
        join
        wait_cells(ncell + 3);
        check_cell("R7 status served first", 16'hE000, 16'h0000, 16'h0000);
        check_cell("R7 hit served second", 16'hBFFF, 16'hBFFF, 16'h0001);
        check_cell("R7 raw served last", 16'hD300, 16'h1234, 16'h5678);

        // R11 reset clears drop count
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check("R11 drop_count cleared by reset", {40'd0, drop_count}, 48'd0);

        finish_run();
    end
endmodule